// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous request port and an asynchronous byte-wide static RAM with a 19-bit address. Each accepted request becomes one complete memory cycle on the chip-select (active low), write-strobe (active low) and output-enable (active low) pins, with the address held steady and the bidirectional data bus driven only inside a bounded window. Every analog interval is a parameter in clock cycles, and the sequencer counts each one out, so the same RTL serves any clock rate and memory speed grade.

Two write sequences are available and chosen by a parameter. In strobe-led mode the chip is selected first and the write strobe forms the pulse. In select-led mode the write strobe falls first and the chip select forms the pulse, so the memory's outputs never turn on during the write. Output enable stays high for the whole write in both modes. A read holds select and output enable low with the write strobe high for the access time, registers the bus on the last access cycle and flags the result for one cycle.

The request port is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle and the minimum spacing since the last accepted request has run out. `req_ready` may depend on `req_we`, because a write that follows a read waits longer. While `req_valid` is high and the request has not been taken, the requester keeps `req_we`, `req_addr` and `req_wdata` unchanged. The read result has no back-pressure: `rd_valid` is a one-cycle pulse and `rd_data` holds its value until the next read completes.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `mem_s_n`, `mem_w_n` and `mem_oe_n` are 1, the controller leaves `mem_dq` undriven (high impedance), `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted on a rising edge with `req_valid` = 1 and `req_ready` = 1. `req_ready` stays 0 until that memory cycle is over. From the cycle after acceptance until the next acceptance, `mem_addr` equals the accepted `req_addr`.
- R3: With WR_S_CTRL = 0, the write pins have three phases. Setup: select 0, strobe 1, for T_ASU cycles. Pulse: both 0. Hold: select 0, strobe 1, for one cycle. After that, both pins return to 1. The byte is stored at the accepted address.
- R4: With WR_S_CTRL = 1, the write pins have three phases. Setup: select 1, strobe 0, for T_ASU cycles. Pulse: both 0. Hold: select 1, strobe 0, for one cycle. After that, both pins return to 1. The byte is stored at the accepted address.
- R5: During a write, `mem_oe_n` is 1 in every cycle. The controller drives `req_wdata` onto `mem_dq` only from the second pulse cycle through the hold cycle. It leaves `mem_dq` undriven in every other cycle, including the cycle in which the strobe falls.
- R6: A read holds select 0, strobe 1 and output enable 0 for T_ACC cycles, starting in the cycle after acceptance. Then all three pins return to 1.
- R7: The bus value seen in the last access cycle appears on `rd_data`, with `rd_valid` = 1, for exactly the following cycle. `rd_data` holds that value afterwards.
- R8: Two accepted requests are at least T_CYC cycles apart. The same applies to read after read, write after write and write after read.
- R9: A write accepted after a read is at least T_CYC + T_TURN cycles after that read.
- R10: The write pulse lasts max(T_WP, T_DSU + 1) cycles. This leaves at least T_DSU cycles of driven data before the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle flag for new read data |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 19 | Memory address pins |
| mem_s_n | output | 1 | Chip select, active low |
| mem_w_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
The bench builds two instances that share one request port: one in strobe-led mode with T_WP = 3 and T_DSU = 1, the other in select-led mode with T_WP = 2 and T_DSU = 2. Both get T_ASU = 1, T_ACC = 3, T_CYC = 6 and T_TURN = 2. Both instances therefore have a three-cycle pulse, and the second one reaches that length only through the data-setup rule. The short values put every phase, the six-cycle spacing and the eight-cycle read-to-write spacing inside a handful of cycles, where each pin can be compared cycle by cycle. A simple memory model on each bus stores bytes when the select/strobe overlap ends, so read-back checks confirm that data lands at address 0 and at the top address in both modes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_READ
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned top);
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned T_ASU     = 1,
  parameter int unsigned PULSE_LEN = 7,
  parameter int unsigned T_ACC     = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_we,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   capture,
  output logic   idle
);
  localparam int unsigned TOP    = max2(max2(T_ASU, PULSE_LEN), T_ACC);
  localparam int unsigned CW     = cnt_width(TOP);
  localparam logic [CW-1:0] ASU_LD = CW'((T_ASU > 0) ? T_ASU - 1 : 0);
  localparam logic [CW-1:0] PLS_LD = CW'(PULSE_LEN - 1);
  localparam logic [CW-1:0] ACC_LD = CW'(T_ACC - 1);
  localparam bit HAS_SETUP = (T_ASU > 0);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (!start_we) begin
            phase_d = PH_READ;
            cnt_d   = ACC_LD;
          end else if (HAS_SETUP) begin
            phase_d = PH_SETUP;
            cnt_d   = ASU_LD;
          end else begin
            phase_d = PH_PULSE;
            cnt_d   = PLS_LD;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_PULSE;
          cnt_d   = PLS_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt_zero) phase_d = PH_HOLD;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_HOLD: phase_d = PH_IDLE;
      PH_READ: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign capture = (phase_q == PH_READ) && cnt_zero;
  assign idle    = (phase_q == PH_IDLE);

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter bit S_CTRL = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_q,
  input  phase_e phase_d,
  output logic   s_n,
  output logic   w_n,
  output logic   oe_n,
  output logic   drive_en
);
  logic side_s_n, side_w_n;
  logic s_d, w_d, oe_d, drv_d;

  generate
    if (S_CTRL) begin : g_sel_led
      assign side_s_n = 1'b1;
      assign side_w_n = 1'b0;
    end else begin : g_strobe_led
      assign side_s_n = 1'b0;
      assign side_w_n = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (phase_d)
      PH_SETUP, PH_HOLD: {s_d, w_d, oe_d} = {side_s_n, side_w_n, 1'b1};
      PH_PULSE:          {s_d, w_d, oe_d} = 3'b001;
      PH_READ:           {s_d, w_d, oe_d} = 3'b010;
      default:           {s_d, w_d, oe_d} = 3'b111;
    endcase
    drv_d = ((phase_d == PH_PULSE) && (phase_q == PH_PULSE)) || (phase_d == PH_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_n      <= 1'b1;
      w_n      <= 1'b1;
      oe_n     <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      s_n      <= s_d;
      w_n      <= w_d;
      oe_n     <= oe_d;
      drive_en <= drv_d;
    end
  end

endmodule

// File: rtl/sram_ctl_pace.sv
module sram_ctl_pace
  import sram_ctl_pkg::*;
#(
  parameter int unsigned T_CYC  = 9,
  parameter int unsigned T_TURN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_we,
  input  logic idle,
  input  logic req_we,
  output logic ready
);
  localparam int unsigned CW = cnt_width(T_CYC + T_TURN);
  localparam logic [CW-1:0] LD_ANY = CW'((T_CYC > 0) ? T_CYC - 1 : 0);
  localparam logic [CW-1:0] LD_RW  = CW'(((T_CYC > 0) ? T_CYC - 1 : 0) + T_TURN);

  logic [CW-1:0] any_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= '0;
      wr_q  <= '0;
    end else if (accept) begin
      any_q <= LD_ANY;
      wr_q  <= accept_we ? LD_ANY : LD_RW;
    end else begin
      if (any_q != '0) any_q <= any_q - 1'b1;
      if (wr_q  != '0) wr_q  <= wr_q - 1'b1;
    end
  end

  assign ready = idle && (req_we ? (wr_q == '0) : (any_q == '0));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter bit          WR_S_CTRL = 1'b0,
  parameter int unsigned T_ASU     = 1,
  parameter int unsigned T_WP      = 7,
  parameter int unsigned T_DSU     = 5,
  parameter int unsigned T_ACC     = 9,
  parameter int unsigned T_CYC     = 9,
  parameter int unsigned T_TURN    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_s_n,
  output logic              mem_w_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int unsigned PULSE_LEN = max2(max2(T_WP, T_DSU + 1), 1);
  localparam int unsigned ACC_LEN   = max2(T_ACC, 1);

  phase_e            phase_q, phase_d;
  logic              accept, capture, idle, drive_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  assign accept = req_valid && req_ready;

  sram_ctl_seq #(
    .T_ASU    (T_ASU),
    .PULSE_LEN(PULSE_LEN),
    .T_ACC    (ACC_LEN)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .start_we(req_we),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .capture (capture),
    .idle    (idle)
  );

  sram_ctl_pins #(
    .S_CTRL(WR_S_CTRL)
  ) i_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .s_n     (mem_s_n),
    .w_n     (mem_w_n),
    .oe_n    (mem_oe_n),
    .drive_en(drive_en)
  );

  sram_ctl_pace #(
    .T_CYC (T_CYC),
    .T_TURN(T_TURN)
  ) i_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .accept_we(req_we),
    .idle     (idle),
    .req_we   (req_we),
    .ready    (req_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= mem_dq;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq   = drive_en ? wdata_q : {DATA_W{1'bz}};
  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_s_n,
  input logic              mem_w_n,
  input logic              mem_oe_n,
  input logic              drive_en
);

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_s_n && mem_w_n && mem_oe_n && !drive_en));

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_s_n && $past(!mem_s_n)) |-> $stable(mem_addr));

  a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n |-> mem_oe_n);

  a_r5_no_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_w_n) |-> !drive_en);

  a_r5_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!mem_w_n || $past(!mem_w_n)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && !mem_oe_n));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r7_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_s_n  (mem_s_n),
  .mem_w_n  (mem_w_n),
  .mem_oe_n (mem_oe_n),
  .drive_en (drive_en)
);

// File: tb/test_sram_ctl.sv
module sram_model (
  input  logic [18:0] a,
  input  logic        s_n,
  input  logic        w_n,
  input  logic        oe_n,
  inout  wire  [7:0]  dq
);
  logic [7:0] store [logic [18:0]];
  logic wr_act;
  assign wr_act = !s_n && !w_n;
  assign dq = (!s_n && w_n && !oe_n) ? (store.exists(a) ? store[a] : 8'h00) : 8'hzz;
  always @(negedge wr_act) store[a] = dq;
endmodule

module test_sram_ctl;
  localparam int TB_CYC  = 6;
  localparam int TB_TURN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, x_ready, x_rd_valid;
  logic [7:0]  rd_data, x_rd_data;
  logic [18:0] m_addr, x_addr;
  logic        m_s_n, m_w_n, m_oe_n, x_s_n, x_w_n, x_oe_n;
  wire  [7:0]  m_dq, x_dq;
  int cyc = 0, checks = 0, errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_ctl #(.WR_S_CTRL(1'b0), .T_ASU(1), .T_WP(3), .T_DSU(1), .T_ACC(3),
             .T_CYC(TB_CYC), .T_TURN(TB_TURN)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(m_addr),
    .mem_s_n(m_s_n), .mem_w_n(m_w_n), .mem_oe_n(m_oe_n), .mem_dq(m_dq));

  sram_ctl #(.WR_S_CTRL(1'b1), .T_ASU(1), .T_WP(2), .T_DSU(2), .T_ACC(3),
             .T_CYC(TB_CYC), .T_TURN(TB_TURN)) i_sram_ctl_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(x_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(x_rd_valid), .rd_data(x_rd_data), .mem_addr(x_addr),
    .mem_s_n(x_s_n), .mem_w_n(x_w_n), .mem_oe_n(x_oe_n), .mem_dq(x_dq));

  sram_model i_mem_a (.a(m_addr), .s_n(m_s_n), .w_n(m_w_n), .oe_n(m_oe_n), .dq(m_dq));
  sram_model i_mem_b (.a(x_addr), .s_n(x_s_n), .w_n(x_w_n), .oe_n(x_oe_n), .dq(x_dq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // {select, strobe, output enable} and bus, for one instance
  task automatic pins(input string req, input bit sel, input logic [2:0] exp_p,
                      input logic [7:0] exp_dq);
    if (!sel) begin
      chk(req, {29'd0, m_s_n, m_w_n, m_oe_n}, {29'd0, exp_p}, "strobe pins");
      chk(req, {24'd0, m_dq}, {24'd0, exp_dq}, "data bus");
    end else begin
      chk(req, {29'd0, x_s_n, x_w_n, x_oe_n}, {29'd0, exp_p}, "sel-led pins");
      chk(req, {24'd0, x_dq}, {24'd0, exp_dq}, "sel-led data bus");
    end
  endtask

  // called at a falling edge; returns at the falling edge of the first cycle
  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d,
                       output int acc);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", {28'd0, m_s_n, m_w_n, m_oe_n, rd_valid}, 32'he, "pins after reset");
    chk("R1", {24'd0, m_dq}, {24'd0, 8'hzz}, "bus after reset");
    chk("R1", {31'd0, req_ready}, 32'd1, "ready after reset");
  endtask

  task automatic t_write_pins(output int acc);
    logic [7:0] d = 8'hA5;
    issue(1'b1, 19'h12345, d, acc);
    // c0 setup, c1..c3 pulse, c4 hold, c5 idle
    pins("R3", 0, 3'b011, 8'hzz); pins("R4", 1, 3'b101, 8'hzz);
    chk("R2", {31'd0, req_ready}, 32'd0, "ready low in cycle");
    chk("R2", {13'd0, m_addr}, {13'd0, 19'h12345}, "address held");
    @(negedge clk);
    pins("R5", 0, 3'b001, 8'hzz); pins("R5", 1, 3'b001, 8'hzz);
    @(negedge clk);
    pins("R5", 0, 3'b001, d); pins("R10", 1, 3'b001, d);
    @(negedge clk);
    pins("R10", 0, 3'b001, d); pins("R10", 1, 3'b001, d);
    chk("R2", {31'd0, req_ready}, 32'd0, "ready low in pulse");
    @(negedge clk);
    pins("R3", 0, 3'b011, d); pins("R4", 1, 3'b101, d);
    chk("R2", {13'd0, m_addr}, {13'd0, 19'h12345}, "address held in hold");
    @(negedge clk);
    pins("R3", 0, 3'b111, 8'hzz); pins("R4", 1, 3'b111, 8'hzz);
  endtask

  task automatic t_read_pins(input int prev);
    int acc;
    issue(1'b0, 19'h12345, 8'h00, acc);
    chk("R8", acc - prev, TB_CYC, "write to read spacing");
    pins("R6", 0, 3'b010, 8'hA5);
    @(negedge clk); pins("R6", 0, 3'b010, 8'hA5);
    chk("R7", {31'd0, rd_valid}, 32'd0, "no early valid");
    @(negedge clk); pins("R6", 0, 3'b010, 8'hA5);
    @(negedge clk); pins("R6", 0, 3'b111, 8'hzz);
    chk("R7", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'hA5}, "read result");
    chk("R4", {23'd0, x_rd_valid, x_rd_data}, {23'd0, 1'b1, 8'hA5}, "sel-led read back");
    @(negedge clk);
    chk("R7", {23'd0, rd_valid, rd_data}, {23'd0, 1'b0, 8'hA5}, "valid one cycle, data held");
  endtask

  task automatic t_spacing;
    int a0, a1;
    issue(1'b0, 19'h00010, 8'h00, a0);
    issue(1'b1, 19'h00011, 8'h5A, a1);
    chk("R9", a1 - a0, TB_CYC + TB_TURN, "read to write spacing");
    issue(1'b1, 19'h00012, 8'h6B, a0);
    chk("R8", a0 - a1, TB_CYC, "write to write spacing");
    issue(1'b0, 19'h00011, 8'h00, a1);
    issue(1'b0, 19'h00012, 8'h00, a0);
    chk("R8", a0 - a1, TB_CYC, "read to read spacing");
    chk("R7", {24'd0, rd_data}, {24'd0, 8'h5A}, "first of two reads");
    repeat (3) @(negedge clk);
    chk("R7", {24'd0, rd_data}, {24'd0, 8'h6B}, "second of two reads");
  endtask

  task automatic t_edges;
    int a;
    issue(1'b1, 19'h00000, 8'h3C, a);
    issue(1'b1, 19'h7FFFF, 8'hC3, a);
    chk("R2", {13'd0, m_addr}, {13'd0, 19'h7FFFF}, "top address");
    issue(1'b0, 19'h00000, 8'h00, a);
    repeat (3) @(negedge clk);
    chk("R3", {24'd0, rd_data}, {24'd0, 8'h3C}, "address zero stored");
    chk("R4", {24'd0, x_rd_data}, {24'd0, 8'h3C}, "sel-led address zero stored");
    issue(1'b0, 19'h7FFFF, 8'h00, a);
    repeat (3) @(negedge clk);
    chk("R3", {24'd0, rd_data}, {24'd0, 8'hC3}, "top address stored");
    chk("R4", {24'd0, x_rd_data}, {24'd0, 8'hC3}, "sel-led top address stored");
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_pins(acc);
    t_read_pins(acc);
    t_spacing();
    t_edges();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule